// File: doc/BRIEF.md
# EEPROM Write-Completion Poller

This block sits on the host side of a parallel EEPROM. It decides when the memory's internal nonvolatile write has finished. Once a byte or page load has started the internal write, the host pulses `start_i` with the last loaded address, the byte written there, a polling method and a cycle budget. The poller then reads that address again and again through a one-outstanding-request read port until the status bits show the write is finished. It then pulses `done_o`, or it pulses `fail_o` on a confirmed data conflict or when the budget runs out.

Two status methods are offered. In the inverted-bit method, bit 7 of the read reads back complemented while the write runs and true once it is finished. In the toggle method, bit 6 flips on every read while the write runs and holds still once it is finished. The write may end in the middle of a read, so a status that looks finished can come with a byte that differs from the expected one. In that case the poller reads the location twice more before it accepts the result or rejects it.

Top module: `ee_poll_ctrl`

## Requirements
- R1: `start_i` is taken only while `busy_o` is low. At that edge the mode, expected byte, address and timeout are captured, and later changes on those inputs, or further `start_i` pulses while busy, have no effect on the run.
- R2: Each read is a one-cycle `rd_req_o` pulse with `rd_addr_o` equal to the captured address. No new request is issued until `rd_valid_i` has returned, and `rd_valid_i` while idle has no effect.
- R3: Inverted-bit mode (`mode_i`=0): a returned byte whose bit 7 differs from bit 7 of the expected byte means the write is still running, and a new read follows.
- R4: A read that shows completion and equals the expected byte gives a `done_o` pulse in the cycle after the `rd_valid_i` edge. A first read that shows completion gives `done_o` two cycles after the start edge.
- R5: Toggle mode (`mode_i`=1): the first read of a run never shows completion. Completion is seen when bit 6 of a read equals bit 6 of the previous read.
- R6: When a read shows completion but the full byte differs from the expected byte, two confirming reads follow. If both equal the expected byte, `done_o` is pulsed.
- R7: If either confirming read differs from the expected byte, `fail_o` is pulsed and no further read is issued.
- R8: With no decision, `fail_o` rises T cycles after the start edge, where T is the captured `tmo_cycles_i` and a value of 0 acts as 1. A read decision in the same cycle takes precedence.
- R9: `done_o` and `fail_o` are one-cycle pulses, never high together, and `busy_o` is low in the cycle they are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling (taken when idle) |
| mode_i | input | 1 | 0 = inverted bit-7 method, 1 = bit-6 toggle method |
| addr_i | input | AW (17) | Address of the last loaded byte |
| exp_data_i | input | DW (8) | Byte written at that address |
| tmo_cycles_i | input | TW (16) | Timeout budget in clock cycles |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW (17) | Read address |
| rd_valid_i | input | 1 | Read data valid, one pulse per request |
| rd_data_i | input | DW (8) | Returned read data |
| busy_o | output | 1 | Polling run in progress |
| done_o | output | 1 | Write completion pulse |
| fail_o | output | 1 | Conflict or timeout pulse |

## Verification
The assertions assume that the memory side answers each `rd_req_o` with exactly one `rd_valid_i` pulse, that it sends no response before a request, and that the only stray pulses arrive while the poller is idle. The bench's memory model returns each answer one cycle after the request from a scripted byte list, and it can be muted to provoke the timeout. A stray valid is injected only after a run has ended. Mid-run `start_i` pulses and input changes are driven so that the capture rule is checked without breaking the response ordering.

// File: rtl/ee_poll_pkg.sv
package ee_poll_pkg;
  typedef enum logic {
    POLL_INV7 = 1'b0,
    POLL_TOG6 = 1'b1
  } poll_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_CREQ,
    ST_CWAIT
  } poll_st_e;
endpackage

// File: rtl/ee_poll_timer.sv
module ee_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] limit_i,
  input  logic          run_i,
  output logic          hit_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (load_i)                          cnt_q <= limit_i;
    else if (run_i && (cnt_q > TW'(1)))       cnt_q <= cnt_q - TW'(1);
  end

  // a budget of 0 behaves as 1
  assign hit_o = run_i && (cnt_q <= TW'(1));
endmodule

// File: rtl/ee_poll_judge.sv
module ee_poll_judge
  import ee_poll_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DONE_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          sample_i,
  input  poll_mode_e    mode_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] exp_i,
  output logic          ready_o,
  output logic          match_o
);
  logic have_q;
  logic prev_q;
  logic [DW-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (clear_i) begin
      have_q <= 1'b0;
    end else if (sample_i) begin
      have_q <= 1'b1;
      prev_q <= data_i[TOG_BIT];
    end
  end

  for (genvar b = 0; b < DW; b++) begin : g_diff
    assign diff[b] = data_i[b] ^ exp_i[b];
  end

  assign match_o = (diff == '0);

  always_comb begin
    if (mode_i == POLL_INV7) ready_o = !diff[DONE_BIT];
    else                     ready_o = have_q && (data_i[TOG_BIT] == prev_q);
  end
endmodule

// File: rtl/ee_poll_ctrl.sv
module ee_poll_ctrl
  import ee_poll_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 17,
  parameter int TW       = 16,
  parameter int DONE_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [TW-1:0] tmo_cycles_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o
);
  poll_st_e      st_q, st_d;
  poll_mode_e    mode_q;
  logic [DW-1:0] exp_q;
  logic [AW-1:0] addr_q;
  logic          conf_q, conf_d;
  logic          done_d, fail_d;
  logic          accept, tmo_hit, ready, match;

  assign accept = (st_q == ST_IDLE) && start_i;
  assign busy_o = (st_q != ST_IDLE);

  ee_poll_timer #(.TW(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .limit_i (tmo_cycles_i),
    .run_i   (busy_o),
    .hit_o   (tmo_hit)
  );

  ee_poll_judge #(.DW(DW), .DONE_BIT(DONE_BIT), .TOG_BIT(TOG_BIT)) u_judge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .sample_i ((st_q == ST_WAIT) && rd_valid_i),
    .mode_i   (mode_q),
    .data_i   (rd_data_i),
    .exp_i    (exp_q),
    .ready_o  (ready),
    .match_o  (match)
  );

  always_comb begin
    st_d   = st_q;
    conf_d = conf_q;
    done_d = 1'b0;
    fail_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_REQ;
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: if (rd_valid_i) begin
        if (ready && match) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (ready) begin
          conf_d = 1'b0;
          st_d   = ST_CREQ;  // status says finished, byte disagrees: confirm
        end else begin
          st_d   = ST_REQ;
        end
      end
      ST_CREQ: st_d = ST_CWAIT;
      ST_CWAIT: if (rd_valid_i) begin
        if (!match) begin
          fail_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (conf_q) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          conf_d = 1'b1;
          st_d   = ST_CREQ;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (busy_o && tmo_hit && !done_d && !fail_d) begin
      fail_d = 1'b1;
      st_d   = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      conf_q <= 1'b0;
      done_o <= 1'b0;
      fail_o <= 1'b0;
      mode_q <= POLL_INV7;
      exp_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      conf_q <= conf_d;
      done_o <= done_d;
      fail_o <= fail_d;
      if (accept) begin
        mode_q <= poll_mode_e'(mode_i);
        exp_q  <= exp_data_i;
        addr_q <= addr_i;
      end
    end
  end

  assign rd_req_o  = (st_q == ST_REQ) || (st_q == ST_CREQ);
  assign rd_addr_o = addr_q;

  // read outstanding tracker for the handshake check
  logic outst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    outst_q <= 1'b0;
    else if (rd_req_o)              outst_q <= 1'b1;
    else if (rd_valid_i || !busy_o) outst_q <= 1'b0;
  end

  p_req_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  p_one_outstanding_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !outst_q);
  p_addr_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));
  p_done_after_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rd_valid_i));
  p_fail_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> ($past(rd_valid_i) || $past(tmo_hit)));
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |=> !(done_o || fail_o));
  p_idle_on_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |-> !busy_o);
endmodule

// File: tb/ee_poll_ctrl_test.sv
`timescale 1ns/1ps
module ee_poll_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  expb = '0;
  logic [15:0] tmo = 16'd1000;
  logic        rd_req, rd_valid = 1'b0;
  logic [16:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        busy, done, fail;

  int errors = 0, checks = 0;
  logic [7:0]  resp [0:15];
  int          resp_n = 1, rd_idx = 0, addr_bad = 0;
  logic        mem_en = 1'b1, stray = 1'b0;
  logic [16:0] run_addr = '0;
  int          res_cyc;
  logic        res_done, res_fail;

  always #5 clk = ~clk;

  ee_poll_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .addr_i(addr),
    .exp_data_i(expb), .tmo_cycles_i(tmo), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  // memory model: answers each request one cycle later
  always @(posedge clk) begin
    rd_valid <= stray || (mem_en && rd_req);
    if (stray) rd_data <= expb;
    if (mem_en && rd_req) begin
      rd_data <= resp[(rd_idx < resp_n) ? rd_idx : resp_n - 1];
      rd_idx  <= rd_idx + 1;
      if (rd_addr != run_addr) addr_bad <= addr_bad + 1;
    end
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_resp(input int n, input logic [7:0] a, b, c, d, e);
    resp[0] = a; resp[1] = b; resp[2] = c; resp[3] = d; resp[4] = e;
    resp_n = n; rd_idx = 0; addr_bad = 0;
  endtask

  task automatic kick(input logic m, input logic [7:0] x, input logic [16:0] a, input logic [15:0] t);
    @(negedge clk);
    mode = m; expb = x; addr = a; tmo = t; run_addr = a; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; addr = ~a; expb = ~x; mode = ~m; tmo = 16'd3;
  endtask

  task automatic wait_res();
    res_cyc = 0; res_done = 0; res_fail = 0;
    while (!done && !fail && res_cyc < 400) begin
      @(posedge clk); #1; res_cyc++;
    end
    res_done = done; res_fail = fail;
    @(posedge clk); #1;
    chk(!done && !fail && !busy, "R9 pulse width", int'(done | fail), 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail && !rd_req, "R9 reset state", int'(busy | done | fail | rd_req), 0);
  endtask

  task automatic t_inv7_direct();
    set_resp(1, 8'hA5, 0, 0, 0, 0);
    kick(1'b0, 8'hA5, 17'h12345, 16'd1000);
    wait_res();
    chk(res_done && !res_fail, "R4 direct done", int'(res_done), 1);
    chk(res_cyc == 2, "R4 done latency", res_cyc, 2);
    chk(addr_bad == 0, "R2 read address", addr_bad, 0);
    chk(rd_idx == 1, "R2 one read", rd_idx, 1);
  endtask

  task automatic t_inv7_poll();
    set_resp(4, 8'h25, 8'h25, 8'h2A, 8'hA5, 0);
    kick(1'b0, 8'hA5, 17'h00F0F, 16'd1000);
    wait_res();
    chk(res_done, "R3 polled done", int'(res_done), 1);
    chk(rd_idx == 4, "R3 read count", rd_idx, 4);
    chk(res_cyc == 8, "R3 cycles", res_cyc, 8);
    chk(addr_bad == 0, "R1 captured address", addr_bad, 0);
  endtask

  task automatic t_tog6();
    set_resp(5, 8'h65, 8'h25, 8'h65, 8'h25, 8'h25);
    kick(1'b1, 8'h25, 17'h1FFFF, 16'd1000);
    wait_res();
    chk(res_done, "R5 toggle done", int'(res_done), 1);
    chk(rd_idx == 5, "R5 toggle reads", rd_idx, 5);
    set_resp(2, 8'h25, 8'h25, 0, 0, 0);
    kick(1'b1, 8'h25, 17'h00001, 16'd1000);
    wait_res();
    chk(res_done && rd_idx == 2, "R5 first read ignored", rd_idx, 2);
  endtask

  task automatic t_confirm();
    set_resp(3, 8'h80, 8'hA5, 8'hA5, 0, 0);
    kick(1'b0, 8'hA5, 17'h00222, 16'd1000);
    wait_res();
    chk(res_done && rd_idx == 3, "R6 confirm pass", rd_idx, 3);
    chk(res_cyc == 6, "R6 cycles", res_cyc, 6);
    set_resp(3, 8'h80, 8'hA5, 8'h11, 0, 0);
    kick(1'b0, 8'hA5, 17'h00333, 16'd1000);
    wait_res();
    chk(res_fail && !res_done, "R7 second confirm bad", int'(res_fail), 1);
    chk(rd_idx == 3, "R7 reads", rd_idx, 3);
    set_resp(2, 8'h80, 8'h11, 8'hA5, 0, 0);
    kick(1'b0, 8'hA5, 17'h00444, 16'd1000);
    wait_res();
    chk(res_fail && rd_idx == 2, "R7 first confirm bad stops", rd_idx, 2);
  endtask

  task automatic t_timeout();
    mem_en = 1'b0;
    set_resp(1, 8'h00, 0, 0, 0, 0);
    kick(1'b0, 8'hA5, 17'h00555, 16'd20);
    wait_res();
    chk(res_fail, "R8 no response timeout", int'(res_fail), 1);
    chk(res_cyc == 20, "R8 timeout cycle", res_cyc, 20);
    kick(1'b0, 8'hA5, 17'h00555, 16'd0);
    wait_res();
    chk(res_fail && res_cyc == 1, "R8 zero budget", res_cyc, 1);
    mem_en = 1'b1;
    set_resp(1, 8'h00, 0, 0, 0, 0);
    kick(1'b0, 8'hA5, 17'h00666, 16'd15);
    wait_res();
    chk(res_fail && res_cyc == 15, "R8 polling timeout", res_cyc, 15);
    repeat (3) @(posedge clk);
  endtask

  task automatic t_start_ignored();
    set_resp(3, 8'h00, 8'h00, 8'hA5, 0, 0);
    kick(1'b0, 8'hA5, 17'h00777, 16'd1000);
    @(negedge clk); start = 1'b1; mode = 1'b1; addr = 17'h0;
    @(negedge clk); start = 1'b0;
    wait_res();
    chk(res_done && rd_idx == 3, "R1 start ignored while busy", rd_idx, 3);
    chk(addr_bad == 0, "R1 address held", addr_bad, 0);
  endtask

  task automatic t_stray();
    int hits = 0;
    @(negedge clk); stray = 1'b1;
    @(negedge clk); stray = 1'b0;
    repeat (4) begin
      @(negedge clk);
      if (done || fail || busy || rd_req) hits++;
    end
    chk(hits == 0, "R2 idle valid ignored", hits, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_inv7_direct();
    t_inv7_poll();
    t_tog6();
    t_confirm();
    t_timeout();
    t_start_ignored();
    t_stray();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule